// File: doc/BRIEF.md
# SPI Slave Word Engine with Chip-Select Resynchronisation

This block is a clocked SPI slave that exchanges fixed-width words (32 bits by default) with an external master. A deserializer collects bits from the master-to-slave data pin and hands each complete word to the system side. A serializer sends words from the system side on the slave-to-master data pin. The serial clock idles high. Input data is sampled on its rising edge, and the output bit changes on its falling edge. All three pins are brought in through two-flop synchronisers, and their edges are detected in the system clock domain. That clock must run at least four times faster than the serial clock.

The block's main job is word alignment. A release of chip-select, at any point in a word, throws away the bits received so far. It also clears both bit counters and abandons the word being shifted out. The serializer then reloads with an all-ones filler. Framing resumes only when chip-select is low again and the serial clock has been seen at its idle-high level. A master that aborts a transfer therefore always restarts on a clean word boundary.

On the transmit side, the user offers a word through a valid/ready handshake into a single pending slot. The slot is empty when it holds all ones. The serializer takes the pending word (or filler, if the slot is empty) at the last falling edge of the word in flight. The word that follows every resynchronisation is therefore filler. The receive side cannot stall the master, so it has no back-pressure. Each word appears with a one-cycle valid strobe, and the data stays on the port until the next word replaces it.

Top module: `spi_word_slave`

## Requirements
- R1: After reset, `rx_valid_o` is 0, `spi_miso_o` is 1 and `tx_ready_o` is 1.
- R2: The MOSI bit is sampled at each rising SCLK edge, most significant bit first. After exactly 32 sampling edges since the last resynchronisation, `rx_data_o` holds the word and `rx_valid_o` pulses high for exactly one system clock.
- R3: After chip-select goes low, no bit is counted until SCLK has been observed high. A rising SCLK edge that ends a low level seen at chip-select assertion is not counted.
- R4: A chip-select release in the middle of a word discards the partial bits and produces no `rx_valid_o`. The next transfer delivers a correctly aligned word after exactly 32 sampling edges.
- R5: A chip-select release abandons the transmit word in flight and reloads the serializer with the filler 0xFFFFFFFF. The first word shifted out after any resynchronisation is all ones.
- R6: While chip-select is high, `spi_miso_o` is 1 from the third system clock onward.
- R7: `tx_ready_o` is 1 exactly when the pending slot is empty. A word is accepted on `tx_valid_i && tx_ready_o`. While a word is pending, further offers are ignored and the pending word is kept.
- R8: MISO changes only after a falling SCLK edge. The first bit of a word is bit 31 of the user word, followed by lower bits in order. A word accepted during word k is sent as word k+1.
- R9: `rx_data_o` changes only in the cycle where `rx_valid_o` is high. Otherwise it holds its value, with no back-pressure.
- R10: An offered word equal to 0xFFFFFFFF counts as empty. `tx_ready_o` stays 1 after it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck_i | input | 1 | Serial clock from master, idles high |
| spi_csn_i | input | 1 | Active-low chip-select |
| spi_mosi_i | input | 1 | Master-to-slave data |
| spi_miso_o | output | 1 | Slave-to-master data |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe per received word |
| tx_data_i | input | WORD_W | Word offered for transmission |
| tx_valid_i | input | 1 | Offer strobe for `tx_data_i` |
| tx_ready_o | output | 1 | Pending slot empty, offer is taken |

## Verification
Full words with asymmetric patterns (single set bits at each end, alternating nibbles) show whether the bit order is MSB first or reversed, on both data pins. A transfer aborted after five bits, followed by a fresh word checked after 31 and then 32 edges, separates a counter that really restarts from one that keeps the stale count. Asserting chip-select with SCLK low and then raising it checks that the idle-level wait does not count that edge. Random sessions mix words with and without an offered transmit word, and some end in random aborts. They compare the filler-then-pending MISO order against a model, so an off-by-one load point or a lost filler is caught.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  typedef enum logic [1:0] {
    FR_IDLE     = 2'd0,
    FR_WAIT_SCK = 2'd1,
    FR_ACTIVE   = 2'd2
  } frame_state_e;

endpackage

// File: rtl/spi_word_sync.sv
module spi_word_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_word_frame.sv
module spi_word_frame
  import spi_word_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s_i,
  input  logic csn_s_i,
  output logic hold_o,
  output logic sample_o,
  output logic shift_o
);

  frame_state_e state_q, state_d;
  logic         sck_d_q;
  logic         active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      sck_d_q <= 1'b1;
    end else begin
      state_q <= state_d;
      sck_d_q <= sck_s_i;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      FR_IDLE:     if (!csn_s_i) state_d = FR_WAIT_SCK;
      FR_WAIT_SCK: if (csn_s_i) state_d = FR_IDLE;
                   else if (sck_s_i) state_d = FR_ACTIVE;
      FR_ACTIVE:   if (csn_s_i) state_d = FR_IDLE;
      default:     state_d = FR_IDLE;
    endcase
  end

  // Framing is live only in ACTIVE and only while select is still low,
  // so a release cuts off the very edge it coincides with.
  assign active   = (state_q == FR_ACTIVE) && !csn_s_i;
  assign hold_o   = !active;
  assign sample_o = active &&  sck_s_i && !sck_d_q;
  assign shift_o  = active && !sck_s_i &&  sck_d_q;

  // R3: framing is entered only after SCLK was seen high with select low
  a_r3_enter_on_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == FR_ACTIVE) |-> $past(sck_s_i && !csn_s_i));

  // R4: a select release always drops back to idle
  a_r4_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s_i |=> (state_q == FR_IDLE));

endmodule

// File: rtl/spi_word_rx.sv
module spi_word_rx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic         sample_i,
  input  logic         mosi_i,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o
);

  localparam int           CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shreg_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  next_word;

  assign next_word = {shreg_q[W-2:0], mosi_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (hold_i) begin
        shreg_q <= '0;
        cnt_q   <= '0;
      end else if (sample_i) begin
        shreg_q <= next_word;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          rx_data_o  <= next_word;
          rx_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4: partial bits are dropped and the count restarts during hold
  a_r4_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));

  // R2: the word strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R4: a strobe only follows a live sampling edge
  a_r4_valid_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(sample_i && !hold_i));

  // R9: the output word only moves with its strobe
  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_data_o));

endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic         shift_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  output logic         miso_o
);

  localparam int            CW     = $clog2(W);
  localparam logic [CW-1:0] LAST   = CW'(W - 1);
  localparam logic [W-1:0]  FILLER = '1;

  logic [W-1:0]  pending_q;
  logic [W-1:0]  pending_rev;
  logic [W-1:0]  shreg_q;
  logic [CW-1:0] cnt_q;
  logic          load_now;

  // Reverse the user word so the serializer always shifts out bit 0
  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign pending_rev[i] = pending_q[W-1-i];
    end
  endgenerate

  assign tx_ready_o = (pending_q == FILLER);
  assign load_now   = shift_i && !hold_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= FILLER;
      cnt_q   <= '0;
      miso_o  <= 1'b1;
    end else if (hold_i) begin
      shreg_q <= FILLER;
      cnt_q   <= '0;
      miso_o  <= 1'b1;
    end else if (shift_i) begin
      miso_o <= shreg_q[0];
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        shreg_q <= pending_rev;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {1'b1, shreg_q[W-1:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= FILLER;
    end else begin
      if (load_now) pending_q <= FILLER;
      if (tx_valid_i && tx_ready_o) pending_q <= tx_data_i;
    end
  end

  // R5: hold leaves the serializer cleared to filler with MISO high
  a_r5_filler_reload: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (miso_o && (&shreg_q) && (cnt_q == '0)));

  // R7: a held pending word survives until the serializer takes it
  a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready_o && !load_now) |=> $stable(pending_q));

  // R7: accepting a real word closes the slot
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o && !(&tx_data_i)) |=> !tx_ready_o);

  // R8: MISO only moves on a falling SCLK edge or on hold
  a_r8_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !hold_i) |=> $stable(miso_o));

endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck_i,
  input  logic              spi_csn_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic             sck_s, csn_s, mosi_s;
  logic             hold, sample, shift;

  spi_word_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_sck_i, spi_csn_i, spi_mosi_i}),
    .q_o   (pins_s)
  );

  assign {sck_s, csn_s, mosi_s} = pins_s;

  spi_word_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s_i  (sck_s),
    .csn_s_i  (csn_s),
    .hold_o   (hold),
    .sample_o (sample),
    .shift_o  (shift)
  );

  spi_word_rx #(.W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold),
    .sample_i   (sample),
    .mosi_i     (mosi_s),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  spi_word_tx #(.W(WORD_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold),
    .shift_i    (shift),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .miso_o     (spi_miso_o)
  );

  // R6: MISO is high once a raised select has crossed the synchroniser
  a_r6_miso_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_csn_i, 3) |-> spi_miso_o);

endmodule

// File: tb/spi_word_slave_tb.sv
module spi_word_slave_tb;

  localparam int          HALF   = 8;
  localparam logic [31:0] FILLER = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sck, csn, mosi;
  logic        miso;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic [31:0] tx_data;
  logic        tx_valid;
  logic        tx_ready;

  int          checks = 0;
  int          fails  = 0;
  int          rx_seen = 0;
  logic [31:0] rx_last = '0;
  logic [31:0] miso_acc;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  spi_word_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck_i  (sck),
    .spi_csn_i  (csn),
    .spi_mosi_i (mosi),
    .spi_miso_o (miso),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .tx_data_i  (tx_data),
    .tx_valid_i (tx_valid),
    .tx_ready_o (tx_ready)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      rx_seen++;
      rx_last = rx_data;
    end
  end

  function automatic logic [31:0] top_bits(logic [31:0] w, int n);
    return w >> (32 - n);
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  // Mode-3 master: data set on falling edge, MISO captured before rising edge
  task automatic bits(logic [31:0] mo, int first, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sck  = 1'b0;
      mosi = mo[31 - first - i];
      clks(HALF);
      miso_acc = {miso_acc[30:0], miso};
      sck = 1'b1;
      clks(HALF);
    end
  endtask

  task automatic cs_low();
    @(negedge clk);
    csn = 1'b0;
    clks(6);
  endtask

  task automatic cs_high();
    clks(2);
    csn = 1'b1;
    clks(HALF);
  endtask

  task automatic offer(logic [31:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
      summary();
      $finish;
    end
  end

  initial begin
    int          base;
    logic [31:0] wa, wb, wc, wz;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sck = 1'b1; csn = 1'b1; mosi = 1'b0;
    tx_valid = 1'b0; tx_data = '0;
    clks(5);
    rst_n = 1'b1;
    clks(2);

    // R1 reset state
    check_eq("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
    check_eq("R1 miso",     {31'd0, miso},     32'd1);
    check_eq("R1 tx_ready", {31'd0, tx_ready}, 32'd1);

    // R10 all-ones offer leaves the slot empty
    offer(FILLER);
    check_eq("R10 ready after all-ones", {31'd0, tx_ready}, 32'd1);

    // R7 handshake, second offer ignored while pending
    wa = 32'hA5C3_0F1E;
    wb = 32'h1234_5678;
    offer(wa);
    check_eq("R7 ready low when pending", {31'd0, tx_ready}, 32'd0);
    offer(wb);
    check_eq("R7 ready stays low", {31'd0, tx_ready}, 32'd0);

    cs_low();
    miso_acc = '0;
    bits(32'h8000_0001, 0, 32);
    check_eq("R5 first word after resync is filler", miso_acc, FILLER);
    check_eq("R2 one strobe per word", rx_seen, 1);
    check_eq("R2 MSB-first word", rx_last, 32'h8000_0001);
    miso_acc = '0;
    bits(32'h0F0F_55AA, 0, 32);
    check_eq("R8 queued word sent next, MSB first", miso_acc, wa);
    check_eq("R7 later offer ignored", {31'd0, (miso_acc == wb)}, 32'd0);
    check_eq("R2 second word", rx_last, 32'h0F0F_55AA);
    check_eq("R9 data held after strobe", rx_data, 32'h0F0F_55AA);
    check_eq("R7 ready back after load", {31'd0, tx_ready}, 32'd1);
    cs_high();
    check_eq("R6 miso high with select high", {31'd0, miso}, 32'd1);

    // R4/R5 abort after five bits, then a fresh word
    wc = 32'hDEAD_BEEF;
    wz = 32'h3C96_A5F0;
    offer(wc);
    cs_low();
    miso_acc = '0;
    bits(32'h0000_0000, 0, 32);
    check_eq("R5 filler before queued word", miso_acc, FILLER);
    miso_acc = '0;
    bits(32'hFFFF_FFFF, 0, 5);
    check_eq("R8 partial word leads with MSBs", miso_acc & 32'h1F, top_bits(wc, 5));
    base = rx_seen;
    cs_high();
    check_eq("R6 miso high after abort", {31'd0, miso}, 32'd1);
    check_eq("R4 no strobe for cut word", rx_seen, base);
    cs_low();
    miso_acc = '0;
    bits(wz, 0, 31);
    check_eq("R4 no strobe after 31 edges", rx_seen, base);
    bits(wz, 31, 1);
    check_eq("R4 strobe after exactly 32 edges", rx_seen, base + 1);
    check_eq("R4 aligned word after abort", rx_last, wz);
    check_eq("R5 abandoned word replaced by filler", miso_acc, FILLER);
    cs_high();

    // R3 SCLK low when select asserts: the edge back to idle is not counted
    @(negedge clk);
    sck = 1'b0;
    clks(HALF);
    @(negedge clk);
    csn = 1'b0;
    clks(6);
    sck = 1'b1;
    clks(HALF);
    base = rx_seen;
    bits(32'h6B1D_44E2, 0, 31);
    check_eq("R3 idle edge not counted", rx_seen, base);
    bits(32'h6B1D_44E2, 31, 1);
    check_eq("R3 word after idle wait", rx_last, 32'h6B1D_44E2);
    cs_high();

    // Random sessions against the filler/pending model
    for (int s = 0; s < 8; s++) begin
      logic [31:0] exp_cur, exp_nxt, mo, ow;
      int          nw;
      bit          abort;
      nw      = 2 + int'($urandom % 4);
      abort   = ($urandom % 3) == 0;
      exp_cur = FILLER;
      cs_low();
      for (int k = 0; k < nw; k++) begin
        bit last_abort;
        last_abort = abort && (k == nw - 1);
        exp_nxt = FILLER;
        if (!last_abort && ($urandom % 4) != 0) begin
          ow = $urandom;
          check_eq("R7 slot empty before offer", {31'd0, tx_ready}, 32'd1);
          offer(ow);
          exp_nxt = ow;
        end
        mo = $urandom;
        base = rx_seen;
        miso_acc = '0;
        if (last_abort) begin
          int nb;
          nb = 1 + int'($urandom % 31);
          bits(mo, 0, nb);
          cs_high();
          check_eq("R4 random abort drops word", rx_seen, base);
          check_eq("R8 random partial MISO", miso_acc & ((32'd1 << nb) - 1),
                   top_bits(exp_cur, nb));
        end else begin
          bits(mo, 0, 32);
          check_eq("R2 random word", rx_last, mo);
          check_eq("R2 random strobe count", rx_seen, base + 1);
          check_eq("R8 random MISO word", miso_acc, exp_cur);
          exp_cur = exp_nxt;
        end
      end
      if (!abort) cs_high();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule